// File: doc/BRIEF.md
# Forwarding Register File with Gated Read

This block is a small synchronous storage array with one write port and one read port. A write presents an enable, an address and a data word. The word lands in the addressed entry on the rising clock edge. The read port is purely combinational. With its enable high, it returns the addressed entry in the same cycle as the address.

When the read address matches an enabled write in the same cycle, the read port returns the word being written rather than the old contents. A consumer therefore sees a result in the very cycle it is produced, with no extra stall. When the read enable is low, the output is driven to all zeros, so the port can feed an OR-combined bus without a separate mux.

Word width and entry count are parameters. The synchronous active-high reset touches no stored data.

Top module: `regf_top`

## Requirements
- R1: With default parameters the array holds 4 independent entries of 8 bits, and the address ports are $clog2(4) = 2 bits wide; each of addresses 0..3 selects its own entry.
- R2: While rd_en is 0, rd_data is all zeros, regardless of rd_addr, the write port and the stored contents.
- R3: While rd_en is 1, wr_en is 1 and wr_addr equals rd_addr, rd_data equals wr_data of that same cycle.
- R4: While wr_en is 1, wr_data is stored in entry wr_addr at the rising clock edge. A later enabled read of that entry, with no same-address write, returns it.
- R5: While wr_en is 0, no entry changes at the clock edge, whatever wr_addr and wr_data hold.
- R6: The read path has zero latency: changing rd_addr or rd_en changes rd_data within the same cycle, without a clock edge.
- R7: A write to one entry leaves every other entry unchanged.
- R8: Asserting rst for one or more cycles does not clear or alter the stored entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; does not clear storage |
| wr_en | input | 1 | Write enable |
| wr_addr | input | $clog2(DEPTH) | Entry index to write |
| wr_data | input | WIDTH | Word to write |
| rd_en | input | 1 | Read enable; output is zero when low |
| rd_addr | input | $clog2(DEPTH) | Entry index to read |
| rd_data | output | WIDTH | Combinational read word |

## Verification
The assertions assume that every input is at a known value from the first clock edge and that wr_addr stays below DEPTH. The stored-value checks also assume that entries have held a defined value since the first write. The bench drives every input from time zero and uses only the default power-of-two depth, so every address is a real entry. It compares a read only against entries it has already written or is writing in that cycle. Stimulus changes on the falling edge, and reads are sampled before the next rising edge, so all combinations of enables and address pairs are covered without ambiguity about which edge a value belongs to.

// File: rtl/regf_pkg.sv
package regf_pkg;

    localparam int unsigned REGF_DEF_WIDTH = 8;
    localparam int unsigned REGF_DEF_DEPTH = 4;

    // Which source feeds the read port in a given cycle.
    typedef enum logic [1:0] {
        SRC_OFF   = 2'd0,
        SRC_FWD   = 2'd1,
        SRC_ARRAY = 2'd2
    } regf_src_e;

    // Forwarding wins over the array; a disabled port drives zeros.
    function automatic regf_src_e regf_pick_src(input logic rd_en, input logic fwd_hit);
        regf_src_e s;
        if (!rd_en)      s = SRC_OFF;
        else if (fwd_hit) s = SRC_FWD;
        else             s = SRC_ARRAY;
        return s;
    endfunction

endpackage

// File: rtl/regf_array.sv
module regf_array
    import regf_pkg::*;
#(
    parameter int unsigned WIDTH = REGF_DEF_WIDTH,
    parameter int unsigned DEPTH = REGF_DEF_DEPTH,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] arr_word
);

    logic [WIDTH-1:0] ent_q [DEPTH];

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_ent
            logic sel;
            assign sel = wr_en && (wr_addr == AW'(gi));

            always_ff @(posedge clk) begin
                if (sel) ent_q[gi] <= wr_data;
            end

            // R4: an enabled write to this entry lands at the edge.
            p_store_r4: assert property (@(posedge clk) disable iff (rst)
                ($past(wr_en) && ($past(wr_addr) == AW'(gi))) |-> (ent_q[gi] == $past(wr_data)));

            // R5 / R7: without a write to this entry, it keeps its value.
            p_hold_r5: assert property (@(posedge clk) disable iff (rst)
                !($past(wr_en) && ($past(wr_addr) == AW'(gi))) |-> $stable(ent_q[gi]));
        end
    endgenerate

    always_comb begin
        arr_word = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (rd_addr == AW'(k)) arr_word = ent_q[k];
        end
    end

endmodule

// File: rtl/regf_bypass.sv
module regf_bypass
    import regf_pkg::*;
#(
    parameter int unsigned WIDTH = REGF_DEF_WIDTH,
    parameter int unsigned AW    = 2
) (
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [WIDTH-1:0] arr_word,
    output logic [WIDTH-1:0] rd_data
);

    logic      fwd_hit;
    regf_src_e src;

    assign fwd_hit = wr_en && (wr_addr == rd_addr);
    assign src     = regf_pick_src(rd_en, fwd_hit);

    always_comb begin
        unique case (src)
            SRC_FWD:   rd_data = wr_data;
            SRC_ARRAY: rd_data = arr_word;
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/regf_top.sv
module regf_top
    import regf_pkg::*;
#(
    parameter int unsigned WIDTH = REGF_DEF_WIDTH,
    parameter int unsigned DEPTH = REGF_DEF_DEPTH,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] arr_word;

    regf_array #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_array (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .arr_word(arr_word)
    );

    regf_bypass #(.WIDTH(WIDTH), .AW(AW)) u_bypass (
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .arr_word(arr_word),
        .rd_data (rd_data)
    );

    // R2: a disabled read port drives zeros.
    p_gate_zero_r2: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rd_data == '0));

    // R3: a same-cycle write to the read address is forwarded.
    p_forward_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wr_en && (wr_addr == rd_addr)) |-> (rd_data == wr_data));

    // R4: otherwise an enabled read shows the stored entry.
    p_array_read_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !(wr_en && (wr_addr == rd_addr))) |-> (rd_data == arr_word));

endmodule

// File: tb/tb_regf_top.sv
module tb_regf_top;

    localparam int unsigned WIDTH = 8;
    localparam int unsigned DEPTH = 4;
    localparam int unsigned AW    = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [AW-1:0]    wr_addr = '0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             rd_en = 1'b0;
    logic [AW-1:0]    rd_addr = '0;
    logic [WIDTH-1:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    logic [WIDTH-1:0] ref_mem [DEPTH];
    logic             ref_wr  [DEPTH];

    always #4 clk = ~clk;

    regf_top #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
            finish_run();
        end
    end

    task automatic cmp(input string tag, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Check the current read port against the reference rules.
    task automatic check_read(input string tag);
        if (!rd_en)
            cmp({tag, " R2"}, rd_data, '0);
        else if (wr_en && (wr_addr == rd_addr))
            cmp({tag, " R3"}, rd_data, wr_data);
        else if (ref_wr[rd_addr])
            cmp({tag, " R4"}, rd_data, ref_mem[rd_addr]);
    endtask

    // Drive on the falling edge, check before the rising edge, then commit.
    task automatic step(input logic we, input logic [AW-1:0] wa, input logic [WIDTH-1:0] wd,
                        input logic re, input logic [AW-1:0] ra, input string tag);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
        #1;
        check_read(tag);
        @(posedge clk);
        if (we) begin
            ref_mem[wa] = wd;
            ref_wr[wa]  = 1'b1;
        end
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            ref_mem[i] = '0;
            ref_wr[i]  = 1'b0;
        end
        repeat (3) @(posedge clk);
        #1;
        cmp("reset R2", rd_data, '0);
        @(negedge clk);
        rst = 1'b0;

        // R1: four distinct entries, each addressable.
        for (int a = 0; a < DEPTH; a++)
            step(1'b1, AW'(a), WIDTH'(8'h11 * (a + 1)), 1'b0, '0, "fill");
        for (int a = 0; a < DEPTH; a++) begin
            step(1'b0, '0, 8'hFF, 1'b1, AW'(a), "R1 readback");
            cmp("R1 entry", rd_data, WIDTH'(8'h11 * (a + 1)));
        end

        // R2: disabled read under all addresses and a live write.
        for (int a = 0; a < DEPTH; a++)
            step(1'b1, AW'(a), 8'hA5, 1'b0, AW'(a), "R2 gated");

        // R5: wr_en low with changing address/data leaves contents.
        for (int a = 0; a < DEPTH; a++)
            step(1'b0, AW'(a), 8'h3C, 1'b0, '0, "R5 idle");
        for (int a = 0; a < DEPTH; a++) begin
            step(1'b0, '0, '0, 1'b1, AW'(a), "R5 after");
            cmp("R5 unchanged", rd_data, 8'hA5);
        end

        // R3 / R7: exhaustive write/read address pairs, both enables.
        for (int wa = 0; wa < DEPTH; wa++)
            for (int ra = 0; ra < DEPTH; ra++)
                for (int e = 0; e < 4; e++)
                    step(e[0], AW'(wa), WIDTH'(wa * 16 + ra * 4 + e + 1), e[1], AW'(ra), "R3R7 sweep");

        // R6: zero latency, rd_addr and rd_en change between edges.
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b1;
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr = AW'(a);
            #0.5;
            cmp("R6 addr change", rd_data, ref_mem[a]);
        end
        rd_en = 1'b0;
        #0.5;
        cmp("R6 enable drop", rd_data, '0);

        // R8: reset pulse leaves storage intact.
        for (int a = 0; a < DEPTH; a++)
            step(1'b1, AW'(a), WIDTH'(8'hC0 + a), 1'b0, '0, "R8 fill");
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int a = 0; a < DEPTH; a++) begin
            step(1'b0, '0, '0, 1'b1, AW'(a), "R8 after reset");
            cmp("R8 kept", rd_data, WIDTH'(8'hC0 + a));
        end

        // Random traffic across all rules.
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0], AW'(r[3:2]), WIDTH'(r[15:8]), r[1], AW'(r[5:4]), "random");
        end

        finish_run();
    end

endmodule